// File: doc/BRIEF.md
# Banked Address Mapper with Text-Page Shadowing

This block translates every 24-bit CPU address into a place to access. The address is split into an 8-bit bank and a 16-bit offset. Each address maps to one of three targets: fast RAM, a small slow RAM area that the display logic also reads, or ROM. An address can also fall into a window for IO devices, or into no target at all. For each address the block gives a physical address and a memory write strobe. When shadowing applies to a write, it also gives a second physical address that receives the same byte. All of these outputs are combinational and follow the input address in the same cycle.

The block holds three pieces of state:
- An 8-bit shadow configuration byte, loaded through a dedicated write port.
- Two soft-switch flags, set and cleared by accesses to fixed offsets in the IO window.
  - `dual_store` gates bank redirection.
  - `alt_page` selects the alternate page.

When both flags are set, the text page of bank $00 is steered into bank $01. Writes to the text page of bank $00 or $01 can then be copied one-way into the matching slow bank, $E0 or $E1. ROM sits in the top banks and is mirrored into the upper part of the four system banks. ROM never receives a write.

Top module: `banked_mapper`

## Requirements
- R1: After reset, the configuration byte is $00 (every overlay and shadow enabled) and both soft switches are clear.
- R2: Banks 256-ROM_BANKS..$FF (default $FC..$FF) decode as ROM, region code 2. The physical address is (bank-$FC)*$10000+offset, so $FC:0000 gives ROM byte 0 and $FF:FFFF gives byte $3FFFF.
- R3: A ROM-mapped address never asserts mem_we_o or shadow_we_o, even for a valid write.
- R4: In banks $00, $01, $E0 and $E1, offsets $D000..$FFFF read from the top ROM bank (physical $30000+offset) whenever overlays are on for that bank. Offset $FFFF therefore gives the last ROM byte.
- R5: Bit 6 of the configuration byte turns overlays off in banks $00 and $01 only. With the byte set to $5F, every address $00:0000..$7F:FFFF is RAM (code 1) with a physical address equal to the CPU address, and a valid write asserts mem_we_o.
- R6: With overlays on, offsets $C000..$C0FF in the four system banks decode as IO (code 3). The physical address is the offset, and mem_we_o stays low.
- R7: Valid IO accesses to the soft switches change them, and the new value takes effect on the next cycle:
  - offset $C000 clears `dual_store` and $C001 sets it;
  - offset $C054 clears `alt_page` and $C055 sets it;
  - an access with cpu_valid low changes neither switch.
- R8: While both switches are set, offsets $0400..$07FF of bank $00 map to bank $01 (physical $1_0400..$1_07FF) for reads and writes. With only one switch set, there is no redirection.
- R9: A valid RAM write whose bank after redirection is $00 or $01, at offsets $0400..$07FF, with configuration bit 0 clear, asserts shadow_we_o. shadow_addr_o is then FAST_BANKS*$10000 + (bank bit 0)*$10000 + offset. Reads never shadow, and bit 0 set blocks shadowing.
- R10: Banks $E0 and $E1 outside the overlays are RAM at FAST_BANKS*$10000 + (bank bit 0)*$10000 + offset. A write to them never asserts shadow_we_o.
- R11: Banks FAST_BANKS..$DF and $E2 up to the first ROM bank decode as unmapped (code 0), with mem_we_o low.
- R12: All decode outputs follow cpu_addr, cpu_write and cpu_valid in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU address, bank in bits 23:16 |
| cpu_valid | input | 1 | Access qualifier; gates writes and soft-switch updates |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Loads the shadow configuration byte |
| cfg_wdata | input | 8 | New configuration byte (bit 0 text-page shadow inhibit, bit 6 overlay inhibit) |
| region_o | output | 2 | 0 unmapped, 1 RAM, 2 ROM, 3 IO |
| prim_addr_o | output | PHYS_W (24) | Primary physical address |
| mem_we_o | output | 1 | Write strobe for the primary RAM target |
| shadow_we_o | output | 1 | Write strobe for the mirrored slow-RAM target |
| shadow_addr_o | output | PHYS_W (24) | Mirrored slow-RAM physical address |

## Verification
The bench builds the block with its defaults: FAST_BANKS = 128 and ROM_BANKS = 4. With these values, every bank edge sits within an 8-bit bank number: $7F/$80 at the top of fast RAM, $DF/$E0 and $E1/$E2 around the slow banks, and $FB/$FC at the ROM base. Random addresses are weighted toward these edges and toward the offsets where the decode changes: $0400/$07FF, $C000/$C0FF and $D000/$FFFF. Directed sequences step the two soft switches through every combination and change the configuration byte between them.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    typedef struct packed {
        logic [7:0] shadow_cfg;
        logic       dual_store;
        logic       alt_page;
    } ctrl_t;

    localparam int unsigned CFG_TXT1_INH = 0;
    localparam int unsigned CFG_OVL_INH  = 6;

    localparam logic [15:0] TXT1_LO = 16'h0400;
    localparam logic [15:0] TXT1_HI = 16'h07FF;
    localparam logic [15:0] ROMWIN_LO = 16'hD000;
    localparam logic [7:0]  IOWIN_PAGE = 8'hC0;

    localparam logic [15:0] SW_DUAL_CLR = 16'hC000;
    localparam logic [15:0] SW_DUAL_SET = 16'hC001;
    localparam logic [15:0] SW_ALT_CLR  = 16'hC054;
    localparam logic [15:0] SW_ALT_SET  = 16'hC055;

endpackage

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
    import mmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  region_e     acc_region,
    input  logic [15:0] acc_offset,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output ctrl_t       ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we) begin
            ctrl_d.shadow_cfg = cfg_wdata;
        end
        if (acc_valid && acc_region == RGN_IO) begin
            case (acc_offset)
                SW_DUAL_CLR: ctrl_d.dual_store = 1'b0;
                SW_DUAL_SET: ctrl_d.dual_store = 1'b1;
                SW_ALT_CLR:  ctrl_d.alt_page   = 1'b0;
                SW_ALT_SET:  ctrl_d.alt_page   = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R7: idle cycles leave the switches and configuration alone
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !cfg_we) |=> $stable(ctrl_q));

    // R7: a valid set access to the dual-store switch is seen next cycle
    a_r7_dual_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_region == RGN_IO && acc_offset == SW_DUAL_SET) |=> ctrl_q.dual_store);

    // R7: a valid clear access to the alternate-page switch is seen next cycle
    a_r7_alt_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_region == RGN_IO && acc_offset == SW_ALT_CLR) |=> !ctrl_q.alt_page);

endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
    import mmap_pkg::*;
#(
    parameter int unsigned FAST_BANKS = 128,
    parameter int unsigned ROM_BANKS  = 4,
    parameter int unsigned PHYS_W     = $clog2(FAST_BANKS) + 17
) (
    input  logic [23:0]       addr,
    input  logic              ovl_inh,
    input  logic              redirect,
    output region_e           region,
    output logic [PHYS_W-1:0] prim_addr,
    output logic [7:0]        eff_bank
);

    localparam int unsigned FAST_BITS = $clog2(FAST_BANKS);
    localparam int unsigned ROM_BITS  = $clog2(ROM_BANKS);
    localparam int unsigned ROM_PAD   = PHYS_W - ROM_BITS - 16;
    localparam logic [7:0]  ROM_FIRST = 8'(256 - ROM_BANKS);
    localparam logic [8:0]  FAST_LIM  = 9'(FAST_BANKS);

    logic [7:0]  bank;
    logic [15:0] off;
    logic        sys_bank;
    logic        ovl_on;
    logic        in_text1;

    always_comb begin
        bank     = addr[23:16];
        off      = addr[15:0];
        sys_bank = (bank[7:1] == 7'h00) || (bank[7:1] == 7'h70);
        ovl_on   = sys_bank && (bank[7] || !ovl_inh);
        in_text1 = (off >= TXT1_LO) && (off <= TXT1_HI);
        eff_bank = (bank == 8'h00 && redirect && in_text1) ? 8'h01 : bank;

        region    = RGN_NONE;
        prim_addr = '0;
        if (bank >= ROM_FIRST) begin
            region    = RGN_ROM;
            prim_addr = {{ROM_PAD{1'b0}}, bank[ROM_BITS-1:0], off};
        end else if (ovl_on && off[15:8] == IOWIN_PAGE) begin
            region    = RGN_IO;
            prim_addr = {{(PHYS_W-16){1'b0}}, off};
        end else if (ovl_on && off >= ROMWIN_LO) begin
            region    = RGN_ROM;
            prim_addr = {{ROM_PAD{1'b0}}, {ROM_BITS{1'b1}}, off};
        end else if ({1'b0, bank} < FAST_LIM) begin
            region    = RGN_RAM;
            prim_addr = {1'b0, eff_bank[FAST_BITS-1:0], off};
        end else if (sys_bank) begin
            region    = RGN_RAM;
            prim_addr = {1'b1, {(FAST_BITS-1){1'b0}}, bank[0], off};
        end
    end

endmodule

// File: rtl/mmap_wrgate.sv
module mmap_wrgate
    import mmap_pkg::*;
#(
    parameter int unsigned FAST_BANKS = 128,
    parameter int unsigned PHYS_W     = $clog2(FAST_BANKS) + 17
) (
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  region_e           region,
    input  logic [7:0]        eff_bank,
    input  logic [15:0]       offset,
    input  logic              txt1_inh,
    output logic              mem_we,
    output logic              shadow_we,
    output logic [PHYS_W-1:0] shadow_addr
);

    localparam int unsigned FAST_BITS = $clog2(FAST_BANKS);

    logic in_text1;

    always_comb begin
        in_text1    = (offset >= TXT1_LO) && (offset <= TXT1_HI);
        mem_we      = cpu_valid && cpu_write && (region == RGN_RAM);
        shadow_we   = mem_we && !txt1_inh && (eff_bank[7:1] == 7'h00) && in_text1;
        shadow_addr = {1'b1, {(FAST_BITS-1){1'b0}}, eff_bank[0], offset};
    end

endmodule

// File: rtl/banked_mapper.sv
module banked_mapper
    import mmap_pkg::*;
#(
    parameter int unsigned FAST_BANKS = 128,
    parameter int unsigned ROM_BANKS  = 4,
    parameter int unsigned PHYS_W     = $clog2(FAST_BANKS) + 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       cpu_addr,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [1:0]        region_o,
    output logic [PHYS_W-1:0] prim_addr_o,
    output logic              mem_we_o,
    output logic              shadow_we_o,
    output logic [PHYS_W-1:0] shadow_addr_o
);

    localparam int unsigned ROM_BYTES = ROM_BANKS * 65536;

    ctrl_t   ctrl_q;
    region_e region;
    logic [7:0] eff_bank;
    logic    unused_cfg_bits;

    assign unused_cfg_bits = ^{ctrl_q.shadow_cfg[7], ctrl_q.shadow_cfg[5:1]};

    mmap_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (cpu_valid),
        .acc_region (region),
        .acc_offset (cpu_addr[15:0]),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .ctrl_q     (ctrl_q)
    );

    mmap_decode #(
        .FAST_BANKS (FAST_BANKS),
        .ROM_BANKS  (ROM_BANKS),
        .PHYS_W     (PHYS_W)
    ) u_decode (
        .addr      (cpu_addr),
        .ovl_inh   (ctrl_q.shadow_cfg[CFG_OVL_INH]),
        .redirect  (ctrl_q.dual_store && ctrl_q.alt_page),
        .region    (region),
        .prim_addr (prim_addr_o),
        .eff_bank  (eff_bank)
    );

    mmap_wrgate #(
        .FAST_BANKS (FAST_BANKS),
        .PHYS_W     (PHYS_W)
    ) u_wrgate (
        .cpu_valid   (cpu_valid),
        .cpu_write   (cpu_write),
        .region      (region),
        .eff_bank    (eff_bank),
        .offset      (cpu_addr[15:0]),
        .txt1_inh    (ctrl_q.shadow_cfg[CFG_TXT1_INH]),
        .mem_we      (mem_we_o),
        .shadow_we   (shadow_we_o),
        .shadow_addr (shadow_addr_o)
    );

    assign region_o = region;

    // R3: ROM is never written
    a_r3_rom_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_ROM) |-> (!mem_we_o && !shadow_we_o));

    // R2: ROM physical addresses stay inside the ROM
    a_r2_rom_range: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_ROM) |-> (32'(prim_addr_o) < 32'(ROM_BYTES)));

    // R9: a shadow write only accompanies a primary RAM write
    a_r9_shadow_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_we_o |-> (mem_we_o && region == RGN_RAM && cpu_write));

    // R10: shadowing is one-way, nothing from the upper banks is mirrored
    a_r10_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[23:16] >= 8'hE0) |-> !shadow_we_o);

endmodule

// File: tb/tb_banked_mapper.sv
module tb_banked_mapper;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] cpu_addr;
    logic        cpu_valid;
    logic        cpu_write;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [1:0]  region_o;
    logic [23:0] prim_addr_o;
    logic        mem_we_o;
    logic        shadow_we_o;
    logic [23:0] shadow_addr_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  m_dual, m_alt;
    logic [7:0] m_cfg;

    always #2.5 clk = ~clk;

    banked_mapper dut (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_valid (cpu_valid),
        .cpu_write (cpu_write), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .region_o (region_o), .prim_addr_o (prim_addr_o), .mem_we_o (mem_we_o),
        .shadow_we_o (shadow_we_o), .shadow_addr_o (shadow_addr_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h addr=%h", tag, what, act, exp, cpu_addr);
        end
    endtask

    task automatic model(input logic [23:0] a, input logic w, input logic v,
                         output logic [1:0] rg, output logic [23:0] pa, output logic we,
                         output logic swe, output logic [23:0] sa, output string tag);
        logic [7:0]  b;
        logic [15:0] o;
        logic [7:0]  eb;
        bit sys, ovl, txt;
        b = a[23:16]; o = a[15:0];
        sys = (b == 8'h00 || b == 8'h01 || b == 8'hE0 || b == 8'hE1);
        ovl = sys && (b >= 8'hE0 || !m_cfg[6]);
        txt = (o >= 16'h0400 && o <= 16'h07FF);
        rg = 2'd0; pa = '0; we = 1'b0; swe = 1'b0; sa = '0; tag = "R11";
        if (b >= 8'hFC) begin
            rg = 2'd2; pa = {6'd0, b[1:0] - 2'd0, o}; tag = w ? "R3" : "R2";
        end else if (ovl && o[15:8] == 8'hC0) begin
            rg = 2'd3; pa = {8'd0, o}; tag = "R6";
        end else if (ovl && o >= 16'hD000) begin
            rg = 2'd2; pa = {6'd0, 2'b11, o}; tag = w ? "R3" : "R4";
        end else if (b < 8'h80) begin
            eb = (b == 8'h00 && m_dual && m_alt && txt) ? 8'h01 : b;
            rg = 2'd1; pa = {1'b0, eb[6:0], o}; we = v && w;
            swe = we && !m_cfg[0] && eb <= 8'h01 && txt;
            sa = 24'h800000 | {7'd0, eb[0], o};
            tag = (eb != b) ? "R8" : (swe ? "R9" : "R5");
        end else if (sys) begin
            rg = 2'd1; pa = 24'h800000 | {7'd0, b[0], o}; we = v && w; tag = "R10";
        end
    endtask

    task automatic access(input logic [23:0] a, input logic w, input logic v, input string ftag);
        logic [1:0] rg; logic [23:0] pa, sa; logic we, swe; string tag;
        @(negedge clk);
        cpu_addr = a; cpu_write = w; cpu_valid = v; cfg_we = 1'b0;
        #1;
        model(a, w, v, rg, pa, we, swe, sa, tag);
        if (ftag != "") tag = ftag;
        chk(tag, "region", 32'(region_o), 32'(rg));
        if (rg != 2'd0) chk(tag, "prim_addr", 32'(prim_addr_o), 32'(pa));
        chk(tag, "mem_we", 32'(mem_we_o), 32'(we));
        chk(tag, "shadow_we", 32'(shadow_we_o), 32'(swe));
        if (swe) chk(tag, "shadow_addr", 32'(shadow_addr_o), 32'(sa));
        if (v && rg == 2'd3) begin
            case (a[15:0])
                16'hC000: m_dual = 1'b0;
                16'hC001: m_dual = 1'b1;
                16'hC054: m_alt  = 1'b0;
                16'hC055: m_alt  = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic set_cfg(input logic [7:0] val);
        @(negedge clk);
        cpu_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = val;
        m_cfg = val;
    endtask

    function automatic logic [7:0] pick_bank();
        logic [7:0] lst [12] = '{8'h00, 8'h01, 8'hE0, 8'hE1, 8'h7F, 8'h80,
                                 8'hDF, 8'hE2, 8'hFB, 8'hFC, 8'hFF, 8'h3A};
        if ($urandom_range(3) == 0) return 8'($urandom);
        return lst[$urandom_range(11)];
    endfunction

    function automatic logic [15:0] pick_off();
        logic [15:0] lst [10] = '{16'h0400, 16'h07FF, 16'h03FF, 16'h0800, 16'hC000,
                                  16'hC0FF, 16'hC100, 16'hCFFF, 16'hD000, 16'hFFFF};
        if ($urandom_range(2) == 0) return 16'($urandom);
        return lst[$urandom_range(9)];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cpu_addr = '0; cpu_valid = 1'b0; cpu_write = 1'b0;
        cfg_we = 1'b0; cfg_wdata = '0;
        m_dual = 1'b0; m_alt = 1'b0; m_cfg = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: configuration $00 and switches clear after reset
        access(24'h000400, 1'b1, 1'b1, "R1");
        access(24'h00C000, 1'b0, 1'b1, "R1");
        // R12: same-cycle response
        access(24'h011234, 1'b1, 1'b1, "R12");
        // R2 / R3 ROM banks
        access(24'hFC0000, 1'b0, 1'b1, "R2");
        access(24'hFFFFFF, 1'b0, 1'b1, "R2");
        access(24'hFC0000, 1'b1, 1'b1, "R3");
        // R4 mirror of last ROM byte
        access(24'h00FFFF, 1'b0, 1'b1, "R4");
        access(24'h01FFFF, 1'b0, 1'b1, "R4");
        access(24'hE0FFFF, 1'b0, 1'b1, "R4");
        access(24'hE1FFFF, 1'b1, 1'b1, "R3");
        // R6 IO window
        access(24'hE1C0FF, 1'b1, 1'b1, "R6");
        // R7: only dual_store set, no redirect
        access(24'h00C001, 1'b0, 1'b1, "R7");
        access(24'h000400, 1'b1, 1'b1, "R7");
        // R7: invalid access to alt-page set has no effect
        access(24'h00C055, 1'b0, 1'b0, "R7");
        access(24'h0007FF, 1'b1, 1'b1, "R7");
        // R8: both set, bank 00 text page goes to bank 01 and mirrors to E1
        access(24'h00C055, 1'b0, 1'b1, "R7");
        access(24'h000400, 1'b1, 1'b1, "R8");
        access(24'h0007FF, 1'b0, 1'b1, "R8");
        access(24'h000800, 1'b1, 1'b1, "R8");
        // R10: write to E1 is not mirrored
        access(24'hE10400, 1'b1, 1'b1, "R10");
        // R7: clear alt page, redirect drops
        access(24'hE0C054, 1'b0, 1'b1, "R7");
        access(24'h000400, 1'b1, 1'b1, "R7");
        // R5 / R9: overlays and text shadow off
        set_cfg(8'h5F);
        access(24'h00C001, 1'b1, 1'b1, "R5");
        access(24'h00FFFF, 1'b1, 1'b1, "R5");
        access(24'h7FFFFF, 1'b1, 1'b1, "R5");
        access(24'h010400, 1'b1, 1'b1, "R9");
        access(24'hE0FFFF, 1'b0, 1'b1, "R4");
        // R11 unmapped banks
        access(24'h800000, 1'b1, 1'b1, "R11");
        access(24'hDFFFFF, 1'b0, 1'b1, "R11");
        access(24'hE20000, 1'b1, 1'b1, "R11");
        access(24'hFBFFFF, 1'b0, 1'b1, "R11");

        // Constrained random mix
        for (int i = 0; i < 5000; i++) begin
            int sel;
            sel = $urandom_range(19);
            if (sel == 0) begin
                set_cfg({1'b0, 1'($urandom), 5'($urandom), 1'($urandom)});
            end else if (sel < 4) begin
                logic [15:0] sw [4] = '{16'hC000, 16'hC001, 16'hC054, 16'hC055};
                logic [7:0]  sb [4] = '{8'h00, 8'h01, 8'hE0, 8'hE1};
                access({sb[$urandom_range(3)], sw[$urandom_range(3)]}, 1'($urandom), 1'($urandom_range(3) != 0), "");
            end else begin
                access({pick_bank(), pick_off()}, 1'($urandom), 1'($urandom_range(5) != 0), "");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule